// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block sits between the bus interface of a small parallel flash device and its embedded-operation engine. It watches every accepted write cycle and steps through the software protection unlock patterns. When a program, sector erase, block erase or chip erase pattern completes with every cycle correct, it checks the target against the hardware protection pins, the per-block lock bits and the supply flag. If the request is legal, it sends the engine a single start pulse with the operation kind, address and data. Any cycle that breaks a pattern returns the sequencer to standby. A protected or inhibited request is dropped without any pulse.

The array holds eight equal blocks, selected by the top three address bits, and block 7 is the boot block. Unlock cycles compare only the low 15 address bits, so the pattern addresses are 5555h and 2AAAh. A three-cycle product-ID command raises a flag that tells the read path to return ID bytes, and an F0h write clears that flag.

Top module: `flash_cmd_seq`

## Requirements
- R1: AAh@5555h, then 55h@2AAAh, then A0h@5555h, then a fourth write at any address issues a program request. op_start is high in the cycle after the fourth write, with op_kind=1 and op_addr/op_data equal to that write.
- R2: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address issues op_kind=2 (sector erase). Ending the same prefix with 50h issues op_kind=3 (block erase). op_addr is the last write's address.
- R3: The same six-cycle prefix ending in 10h@5555h issues op_kind=4 (chip erase) only while mux_mode=1. It is dropped when mux_mode=0, and also when any block is protected under R6, R7 or R8.
- R4: A write that does not match the expected cycle of a pattern returns the sequencer to standby. A later write that would have completed the pattern issues nothing.
- R5: AAh@5555h, 55h@2AAAh, 90h@5555h sets id_mode in the cycle after the third write. A write of F0h from standby, or as the third cycle of the pattern, clears id_mode.
- R6: While top_lock_n=0, program and erase requests to block 7 (address bits [18:16]=7) are dropped.
- R7: While wp_n=0, program and erase requests to blocks 0 through 6 are dropped. Block 7 is unaffected.
- R8: blk_lock[i]=1 drops requests to block i. A low protection pin drops requests to its blocks even when every lock bit is 0.
- R9: While vdd_ok=0, no program or erase request is issued.
- R10: While eng_busy=1, writes are ignored and the sequencer state is held. A pattern resumes where it stood once busy falls.
- R11: Reset clears op_start and id_mode and returns the sequencer to standby from any state.
- R12: op_start is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| mux_mode | input | 1 | 1 = address-multiplexed mode (chip erase allowed) |
| top_lock_n | input | 1 | Low protects the boot block |
| wp_n | input | 1 | Low protects blocks 0 to 6 |
| blk_lock | input | 8 | Per-block lock bits, 1 = locked |
| vdd_ok | input | 1 | Supply above the write threshold |
| eng_busy | input | 1 | Engine is running an operation |
| op_start | output | 1 | One-cycle start pulse |
| op_kind | output | 3 | 1 program, 2 sector, 3 block, 4 chip erase |
| op_addr | output | 19 | Target address of the request |
| op_data | output | 8 | Program data (last write data) |
| id_mode | output | 1 | Product-ID read mode active |

## Verification
The assertions assume that the protection pins, lock bits, supply flag and mode input do not change in the cycle a final write is accepted, because the properties compare a start pulse with the previous cycle's inputs. The bench drives every input on the falling clock edge. It holds each write for exactly one cycle and changes the pin and lock settings only between complete patterns. All stimulus therefore stays inside that assumption, and each pulse can be traced to a single sampled set of inputs.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    OPK_NONE = 3'd0,
    OPK_PROG = 3'd1,
    OPK_SECT = 3'd2,
    OPK_BLK  = 3'd3,
    OPK_CHIP = 3'd4
  } opk_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PRG,
    ST_ERS1,
    ST_ERS2,
    ST_ERS3
  } seq_e;

  localparam logic [7:0] C_KEY1  = 8'hAA;
  localparam logic [7:0] C_KEY2  = 8'h55;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_ERASE = 8'h80;
  localparam logic [7:0] C_IDIN  = 8'h90;
  localparam logic [7:0] C_EXIT  = 8'hF0;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_BLK   = 8'h50;
endpackage

// File: rtl/fcs_decode.sv
module fcs_decode #(
  parameter int UNLK_W = 15,
  parameter logic [UNLK_W-1:0] KEY_A = 15'h5555,
  parameter logic [UNLK_W-1:0] KEY_B = 15'h2AAA
) (
  input  logic [UNLK_W-1:0] low_addr,
  input  logic [7:0]        data,
  output logic              at_a,
  output logic              at_b,
  output logic              d_key1,
  output logic              d_key2,
  output logic              d_prog,
  output logic              d_erase,
  output logic              d_idin,
  output logic              d_exit,
  output logic              d_chip,
  output logic              d_sect,
  output logic              d_blk
);
  import fcs_pkg::*;

  always_comb begin
    at_a    = (low_addr == KEY_A);
    at_b    = (low_addr == KEY_B);
    d_key1  = (data == C_KEY1);
    d_key2  = (data == C_KEY2);
    d_prog  = (data == C_PROG);
    d_erase = (data == C_ERASE);
    d_idin  = (data == C_IDIN);
    d_exit  = (data == C_EXIT);
    d_chip  = (data == C_CHIP);
    d_sect  = (data == C_SECT);
    d_blk   = (data == C_BLK);
  end
endmodule

// File: rtl/fcs_guard.sv
module fcs_guard #(
  parameter int NBLK  = 8,
  parameter int BLK_W = $clog2(NBLK)
) (
  input  logic [BLK_W-1:0] blk_idx,
  input  logic             top_lock_n,
  input  logic             wp_n,
  input  logic [NBLK-1:0]  blk_lock,
  input  logic             vdd_ok,
  output logic             blk_ok,
  output logic             all_ok
);
  logic [NBLK-1:0] prot;

  for (genvar i = 0; i < NBLK; i++) begin : g_prot
    if (i == NBLK - 1) begin : g_boot
      assign prot[i] = blk_lock[i] | ~top_lock_n;
    end else begin : g_main
      assign prot[i] = blk_lock[i] | ~wp_n;
    end
  end

  always_comb begin
    blk_ok = vdd_ok & ~prot[blk_idx];
    all_ok = vdd_ok & ~(|prot);
  end
endmodule

// File: rtl/fcs_fsm.sv
module fcs_fsm (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_acc,
  input  logic        at_a,
  input  logic        at_b,
  input  logic        d_key1,
  input  logic        d_key2,
  input  logic        d_prog,
  input  logic        d_erase,
  input  logic        d_idin,
  input  logic        d_exit,
  input  logic        d_chip,
  input  logic        d_sect,
  input  logic        d_blk,
  input  logic        mux_mode,
  input  logic        blk_ok,
  input  logic        all_ok,
  output logic        fire,
  output logic [2:0]  fire_kind,
  output logic        id_set,
  output logic        id_clr
);
  import fcs_pkg::*;

  seq_e st, st_nxt;
  opk_e kind;

  always_comb begin
    st_nxt = st;
    fire   = 1'b0;
    kind   = OPK_NONE;
    id_set = 1'b0;
    id_clr = 1'b0;
    if (wr_acc) begin
      case (st)
        ST_IDLE: begin
          if (at_a && d_key1) st_nxt = ST_UNL1;
          else if (d_exit)    id_clr = 1'b1;
        end
        ST_UNL1: st_nxt = (at_b && d_key2) ? ST_UNL2 : ST_IDLE;
        ST_UNL2: begin
          st_nxt = ST_IDLE;
          if (at_a) begin
            if (d_prog)       st_nxt = ST_PRG;
            else if (d_erase) st_nxt = ST_ERS1;
            else if (d_idin)  id_set = 1'b1;
            else if (d_exit)  id_clr = 1'b1;
          end
        end
        ST_PRG: begin
          st_nxt = ST_IDLE;
          kind   = OPK_PROG;
          fire   = blk_ok;
        end
        ST_ERS1: st_nxt = (at_a && d_key1) ? ST_ERS2 : ST_IDLE;
        ST_ERS2: st_nxt = (at_b && d_key2) ? ST_ERS3 : ST_IDLE;
        ST_ERS3: begin
          st_nxt = ST_IDLE;
          if (d_sect) begin
            kind = OPK_SECT;
            fire = blk_ok;
          end else if (d_blk) begin
            kind = OPK_BLK;
            fire = blk_ok;
          end else if (d_chip && at_a) begin
            kind = OPK_CHIP;
            fire = mux_mode & all_ok;
          end
        end
        default: st_nxt = ST_IDLE;
      endcase
    end
    fire_kind = kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W = 19,
  parameter int NBLK   = 8,
  parameter int UNLK_W = 15,
  parameter logic [UNLK_W-1:0] KEY_A = 15'h5555,
  parameter logic [UNLK_W-1:0] KEY_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              mux_mode,
  input  logic              top_lock_n,
  input  logic              wp_n,
  input  logic [NBLK-1:0]   blk_lock,
  input  logic              vdd_ok,
  input  logic              eng_busy,
  output logic              op_start,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              id_mode
);
  localparam int BLK_W = $clog2(NBLK);

  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic at_a, at_b, d_key1, d_key2, d_prog, d_erase, d_idin, d_exit;
  logic d_chip, d_sect, d_blk;
  logic blk_ok, all_ok;
  logic fire, id_set, id_clr;
  logic [2:0] fire_kind;
  logic wr_acc;

  assign wr_acc = wr_en & ~eng_busy;

  fcs_decode #(.UNLK_W(UNLK_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_dec (
    .low_addr(wr_addr[UNLK_W-1:0]), .data(wr_data),
    .at_a(at_a), .at_b(at_b), .d_key1(d_key1), .d_key2(d_key2),
    .d_prog(d_prog), .d_erase(d_erase), .d_idin(d_idin), .d_exit(d_exit),
    .d_chip(d_chip), .d_sect(d_sect), .d_blk(d_blk)
  );

  fcs_guard #(.NBLK(NBLK), .BLK_W(BLK_W)) u_guard (
    .blk_idx(wr_addr[ADDR_W-1 -: BLK_W]), .top_lock_n(top_lock_n),
    .wp_n(wp_n), .blk_lock(blk_lock), .vdd_ok(vdd_ok),
    .blk_ok(blk_ok), .all_ok(all_ok)
  );

  fcs_fsm u_fsm (
    .clk(clk), .rst_n(rst_sn), .wr_acc(wr_acc),
    .at_a(at_a), .at_b(at_b), .d_key1(d_key1), .d_key2(d_key2),
    .d_prog(d_prog), .d_erase(d_erase), .d_idin(d_idin), .d_exit(d_exit),
    .d_chip(d_chip), .d_sect(d_sect), .d_blk(d_blk),
    .mux_mode(mux_mode), .blk_ok(blk_ok), .all_ok(all_ok),
    .fire(fire), .fire_kind(fire_kind), .id_set(id_set), .id_clr(id_clr)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      op_start <= 1'b0;
      id_mode  <= 1'b0;
    end else begin
      op_start <= fire;
      if (id_set)      id_mode <= 1'b1;
      else if (id_clr) id_mode <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      op_kind <= fire_kind;
      op_addr <= wr_addr;
      op_data <= wr_data;
    end
  end
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int ADDR_W = 19,
  parameter int NBLK   = 8,
  parameter int BLK_W  = $clog2(NBLK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_start,
  input logic [2:0]        op_kind,
  input logic [ADDR_W-1:0] op_addr,
  input logic              mux_mode,
  input logic              top_lock_n,
  input logic              wp_n,
  input logic [NBLK-1:0]   blk_lock,
  input logic              vdd_ok,
  input logic              eng_busy
);
  logic [NBLK-1:0]  lock_d;
  logic [BLK_W-1:0] tgt;

  always_ff @(posedge clk) lock_d <= blk_lock;
  assign tgt = op_addr[ADDR_W-1 -: BLK_W];

  p_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  p_supply_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(vdd_ok));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !$past(eng_busy));

  p_chip_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind == 3'd4) |-> $past(mux_mode));

  p_boot_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind != 3'd4 && tgt == BLK_W'(NBLK-1)) |-> $past(top_lock_n));

  p_wp_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind != 3'd4 && tgt != BLK_W'(NBLK-1)) |-> $past(wp_n));

  p_lockbit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind != 3'd4) |-> !lock_d[tgt]);

  p_kind_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (op_kind >= 3'd1 && op_kind <= 3'd4));
endmodule

bind flash_cmd_seq fcs_checker #(.ADDR_W(ADDR_W), .NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
  .op_addr(op_addr), .mux_mode(mux_mode), .top_lock_n(top_lock_n),
  .wp_n(wp_n), .blk_lock(blk_lock), .vdd_ok(vdd_ok), .eng_busy(eng_busy)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [18:0] wr_addr;
  logic [7:0]  wr_data;
  logic        mux_mode, top_lock_n, wp_n, vdd_ok, eng_busy;
  logic [7:0]  blk_lock;
  logic        op_start, id_mode;
  logic [2:0]  op_kind;
  logic [18:0] op_addr;
  logic [7:0]  op_data;

  int checks = 0;
  int errors = 0;

  localparam logic [18:0] KA = 19'h05555;
  localparam logic [18:0] KB = 19'h02AAA;

  always #4 clk = ~clk;

  flash_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mux_mode(mux_mode), .top_lock_n(top_lock_n), .wp_n(wp_n), .blk_lock(blk_lock),
    .vdd_ok(vdd_ok), .eng_busy(eng_busy), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock3(input logic [7:0] cmd);
    wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, cmd);
  endtask

  task automatic erase6(input logic [18:0] a, input logic [7:0] cmd);
    unlock3(8'h80); wr(KA, 8'hAA); wr(KB, 8'h55); wr(a, cmd);
  endtask

  task automatic expect_start(input string tag, input logic [2:0] k,
                              input logic [18:0] a, input logic [7:0] d);
    chk({tag, " start"}, op_start, 1);
    chk({tag, " kind"}, op_kind, k);
    chk({tag, " addr"}, op_addr, a);
    if (k == 3'd1) chk({tag, " data"}, op_data, d);
    @(negedge clk);
    chk("R12 pulse width", op_start, 0);
  endtask

  task automatic expect_none(input string tag);
    chk(tag, op_start, 0);
    @(negedge clk);
    chk(tag, op_start, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 op_start after reset", op_start, 0);
    chk("R11 id_mode after reset", id_mode, 0);
    unlock3(8'hA0);
    do_reset();
    wr(19'h11111, 8'h3C);
    expect_none("R11 sequence cleared by reset");
    unlock3(8'h90);
    chk("R5 id set before reset", id_mode, 1);
    do_reset();
    chk("R11 id_mode cleared", id_mode, 0);
  endtask

  task automatic t_prog();
    unlock3(8'hA0); wr(19'h12345, 8'h5A);
    expect_start("R1 program blk1", 3'd1, 19'h12345, 8'h5A);
    unlock3(8'hA0); wr(19'h00000, 8'h00);
    expect_start("R1 program blk0", 3'd1, 19'h00000, 8'h00);
  endtask

  task automatic t_erase();
    erase6(19'h23000, 8'h30);
    expect_start("R2 sector erase", 3'd2, 19'h23000, 8'h00);
    erase6(19'h40000, 8'h50);
    expect_start("R2 block erase", 3'd3, 19'h40000, 8'h00);
  endtask

  task automatic t_chip();
    mux_mode = 1'b1;
    erase6(KA, 8'h10);
    expect_start("R3 chip erase mux", 3'd4, KA, 8'h00);
    mux_mode = 1'b0;
    erase6(KA, 8'h10);
    expect_none("R3 chip erase non-mux dropped");
    mux_mode = 1'b1;
    blk_lock = 8'h02;
    erase6(KA, 8'h10);
    expect_none("R3 chip erase with locked block dropped");
    blk_lock = 8'h00;
  endtask

  task automatic t_abort();
    wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'h77);
    wr(19'h11000, 8'h12);
    expect_none("R4 bad command byte aborts");
    wr(19'h01234, 8'hAA); wr(KB, 8'h55); wr(KA, 8'hA0); wr(19'h11000, 8'h12);
    expect_none("R4 bad unlock address aborts");
    unlock3(8'h80); wr(KA, 8'hAA); wr(KA, 8'h55); wr(19'h20000, 8'h30);
    expect_none("R4 erase prefix mismatch aborts");
    unlock3(8'hA0); wr(19'h31000, 8'hC3);
    expect_start("R4 recovers after abort", 3'd1, 19'h31000, 8'hC3);
  endtask

  task automatic t_id();
    unlock3(8'h90);
    chk("R5 id_mode set", id_mode, 1);
    wr(19'h00100, 8'hF0);
    chk("R5 id_mode cleared by F0", id_mode, 0);
    unlock3(8'h90);
    unlock3(8'hF0);
    chk("R5 id_mode cleared by F0 pattern", id_mode, 0);
  endtask

  task automatic t_boot();
    top_lock_n = 1'b0;
    unlock3(8'hA0); wr(19'h7ABCD, 8'h11);
    expect_none("R6 boot program dropped");
    erase6(19'h70000, 8'h30);
    expect_none("R6 boot sector erase dropped");
    unlock3(8'hA0); wr(19'h3ABCD, 8'h22);
    expect_start("R6 other block unaffected", 3'd1, 19'h3ABCD, 8'h22);
    top_lock_n = 1'b1;
  endtask

  task automatic t_wp();
    wp_n = 1'b0;
    unlock3(8'hA0); wr(19'h20010, 8'h33);
    expect_none("R7 block2 program dropped");
    erase6(19'h60000, 8'h50);
    expect_none("R7 block6 erase dropped");
    unlock3(8'hA0); wr(19'h7F000, 8'h44);
    expect_start("R7 boot unaffected by wp", 3'd1, 19'h7F000, 8'h44);
    wp_n = 1'b1;
  endtask

  task automatic t_lock();
    blk_lock = 8'h20;
    unlock3(8'hA0); wr(19'h50000, 8'h55);
    expect_none("R8 locked block5 dropped");
    unlock3(8'hA0); wr(19'h40004, 8'h66);
    expect_start("R8 unlocked block4 issued", 3'd1, 19'h40004, 8'h66);
    blk_lock = 8'h00; top_lock_n = 1'b0;
    unlock3(8'hA0); wr(19'h70001, 8'h77);
    expect_none("R8 pin overrides clear lock bits");
    top_lock_n = 1'b1;
  endtask

  task automatic t_vdd();
    vdd_ok = 1'b0;
    unlock3(8'hA0); wr(19'h10000, 8'h88);
    expect_none("R9 program inhibited low supply");
    erase6(19'h10000, 8'h30);
    expect_none("R9 erase inhibited low supply");
    vdd_ok = 1'b1;
  endtask

  task automatic t_busy();
    eng_busy = 1'b1;
    unlock3(8'hA0); wr(19'h10000, 8'h99);
    expect_none("R10 busy ignores whole sequence");
    eng_busy = 1'b0;
    wr(KA, 8'hAA); wr(KB, 8'h55);
    eng_busy = 1'b1;
    wr(19'h00000, 8'h00); wr(19'h12000, 8'hFF);
    expect_none("R10 busy writes ignored mid sequence");
    eng_busy = 1'b0;
    wr(KA, 8'hA0); wr(19'h12000, 8'hA5);
    expect_start("R10 sequence resumes after busy", 3'd1, 19'h12000, 8'hA5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    mux_mode = 1'b1; top_lock_n = 1'b1; wp_n = 1'b1;
    blk_lock = 8'h00; vdd_ok = 1'b1; eng_busy = 1'b0;
    do_reset();
    t_reset();
    t_prog();
    t_erase();
    t_chip();
    t_abort();
    t_id();
    t_boot();
    t_wp();
    t_lock();
    t_vdd();
    t_busy();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule